// File: doc/BRIEF.md
# Arithmetic Unit with Condition Code

This block is the arithmetic stage of a small 16-bit processor datapath. It receives an instruction word and two operand values already read from a register file elsewhere. It decodes the operation from the top four instruction bits and produces one of three results: a sum, a bitwise AND, or a bitwise complement. The second operand is either the register value or a sign-extended 5-bit immediate taken from the instruction. The block also reports which register the result is meant for.

The block holds a 2-bit condition code in a register. When the update strobe is high at a clock edge, the code is reloaded from a value that the block classifies as negative, zero or positive. That value is either the ALU result or a separate load value coming from the memory path. A combinational branch-match output tells whether the enable bits in instruction bits 11:9 select the condition code that is currently held.

Top module: `alu_ccode`

## Requirements
- R1: When instruction bit 5 is 0, the second operand is `src_b`.
- R2: When instruction bit 5 is 1, the second operand is bits 4:0 of the instruction, sign-extended to 16 bits (range -16 to +15).
- R3: Opcode 4'b0001 (bits 15:12) gives `result` = first operand + second operand, wrapped modulo 2^16. There is no carry output.
- R4: Opcode 4'b0101 gives `result` = bitwise AND of `src_a` and the second operand.
- R5: Opcode 4'b1001 gives `result` = bitwise complement of `src_a`. Bit 5 and `src_b` have no effect on it.
- R6: Any other opcode gives `result` = 0.
- R7: `dest_idx` always equals instruction bits 11:9.
- R8: When `cc_update` is 1 at a rising edge and `cc_sel_load` is 0, the classified value is `result`. After that edge, `cc` is 2'd2 (negative) if bit 15 of the value is set, 2'd1 (zero) if the value is zero, and 2'd0 (positive) otherwise. Code 2'd3 never appears.
- R9: When `cc_update` and `cc_sel_load` are both 1 at a rising edge, the value classified is `load_val` instead of `result`.
- R10: When `cc_update` is 0 at an edge, `cc` keeps its value.
- R11: While `rst_n` is low, `cc` is cleared to 2'd0.
- R12: `branch_match` = (bit 11 and cc==2) or (bit 10 and cc==1) or (bit 9 and cc==0). It is combinational from the held code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 16 | Instruction word |
| src_a | input | 16 | First operand (register named by bits 8:6) |
| src_b | input | 16 | Second register operand (register named by bits 2:0) |
| load_val | input | 16 | Loaded value, used for the condition update when selected |
| cc_update | input | 1 | Strobe that loads the condition code |
| cc_sel_load | input | 1 | 1 selects `load_val` as the value to classify |
| result | output | 16 | Operation result |
| dest_idx | output | 3 | Destination register index |
| cc | output | 2 | Condition code: 0 positive, 1 zero, 2 negative |
| branch_match | output | 1 | Branch enable bits select the current code |

## Verification
The vector table covers each of the three operations with both register and immediate operands.
- The immediate cases use -1, -16, -2, +15 and +5. These separate correct sign extension from zero extension.
- A register operand that differs from the immediate field shows which source was selected.
- The sum of 0xFFFF and 2 checks wrap-around.
- A complement run with bit 5 set and an unrelated `src_b` shows that the second operand is ignored.
- A non-arithmetic opcode checks the zero result.

Directed steps drive the condition code to each of zero, negative and positive, and check `branch_match` under every code. They also hold the strobe low while the inputs would change the code. Finally, they take the classified value from the load path while `result` would classify differently.

// File: rtl/alu_ccode.sv
module alu_ccode #(
  parameter int W = 16,
  parameter int IMM_W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [15:0]  instr,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] load_val,
  input  logic         cc_update,
  input  logic         cc_sel_load,
  output logic [W-1:0] result,
  output logic [2:0]   dest_idx,
  output logic [1:0]   cc,
  output logic         branch_match
);
  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_AND = 4'b0101;
  localparam logic [3:0] OP_NOT = 4'b1001;
  localparam logic [1:0] CC_POS = 2'd0;
  localparam logic [1:0] CC_ZER = 2'd1;
  localparam logic [1:0] CC_NEG = 2'd2;

  logic [3:0]   opc;
  logic [W-1:0] imm_ext, opnd_b, cls_val;
  logic [1:0]   cc_next;

  assign opc      = instr[15:12];
  assign dest_idx = instr[11:9];
  assign imm_ext  = {{(W-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
  assign opnd_b   = instr[5] ? imm_ext : src_b;

  always_comb begin
    case (opc)
      OP_ADD:  result = src_a + opnd_b;
      OP_AND:  result = src_a & opnd_b;
      OP_NOT:  result = ~src_a;
      default: result = '0;
    endcase
  end

  assign cls_val = cc_sel_load ? load_val : result;

  always_comb begin
    if (cls_val == '0)     cc_next = CC_ZER;
    else if (cls_val[W-1]) cc_next = CC_NEG;
    else                   cc_next = CC_POS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cc <= CC_POS;
    else if (cc_update) cc <= cc_next;
  end

  assign branch_match = (instr[11] && cc == CC_NEG) ||
                        (instr[10] && cc == CC_ZER) ||
                        (instr[9]  && cc == CC_POS);

  // R8
  cc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) cc != 2'd3);

  // R10
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_update |=> $stable(cc));

  // R8
  cc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_update && !cc_sel_load && result == '0) |=> cc == CC_ZER);

  // R9
  cc_load_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_update && cc_sel_load && load_val[W-1]) |=> cc == CC_NEG);

  // R12
  always_comb begin
    if (rst_n && instr[11:9] == 3'b000)
      br_none_chk: assert (!branch_match);
  end

  // R3
  always_comb begin
    if (opc == OP_ADD && instr[5] && instr[IMM_W-1:0] == '0)
      add_zero_imm_chk: assert (result == src_a);
  end
endmodule

// File: tb/tb_alu_ccode.sv
module tb_alu_ccode;
  logic        clk = 0, rst_n = 0;
  logic [15:0] instr = 0, src_a = 0, src_b = 0, load_val = 0;
  logic        cc_update = 0, cc_sel_load = 0;
  logic [15:0] result;
  logic [2:0]  dest_idx;
  logic [1:0]  cc;
  logic        branch_match;
  int n_chk = 0, n_bad = 0;

  alu_ccode dut (.clk(clk), .rst_n(rst_n), .instr(instr), .src_a(src_a), .src_b(src_b),
    .load_val(load_val), .cc_update(cc_update), .cc_sel_load(cc_sel_load),
    .result(result), .dest_idx(dest_idx), .cc(cc), .branch_match(branch_match));

  always #4 clk = ~clk;

  localparam int NV = 11;
  // {instr, src_a, src_b, expected result}
  localparam logic [63:0] VEC [NV] = '{
    {16'h1443, 16'h0005, 16'h0007, 16'h000C},  // R1 R3 add reg
    {16'h103F, 16'h0005, 16'h1234, 16'h0004},  // R2 imm -1
    {16'h102F, 16'h0001, 16'h1234, 16'h0010},  // R2 imm +15
    {16'h1000, 16'hFFFF, 16'h0002, 16'h0001},  // R3 wrap
    {16'h1E30, 16'h0010, 16'h0000, 16'h0000},  // R2 imm -16
    {16'h5000, 16'hF0F0, 16'h3C3C, 16'h3030},  // R4 reg
    {16'h5A3E, 16'h00FF, 16'h0000, 16'h00FE},  // R4 imm -2
    {16'h5025, 16'hFFFF, 16'h0000, 16'h0005},  // R4 imm +5
    {16'h963F, 16'h00FF, 16'h1234, 16'hFF00},  // R5 bit5 set
    {16'h9000, 16'h0000, 16'hAAAA, 16'hFFFF},  // R5
    {16'h2E05, 16'h0005, 16'h0005, 16'h0000}   // R6
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cc(input logic [15:0] ins, input logic [15:0] a, input logic sel,
                        input logic [15:0] ld);
    @(negedge clk);
    instr = ins; src_a = a; src_b = 0; cc_sel_load = sel; load_val = ld; cc_update = 1;
    @(negedge clk);
    cc_update = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R11 cc in reset", {14'b0, cc}, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    check("R11 cc after reset", {14'b0, cc}, 16'h0000);
    for (int i = 0; i < NV; i++) begin
      instr = VEC[i][63:48]; src_a = VEC[i][47:32]; src_b = VEC[i][31:16];
      #1;
      check("R1-6 result", result, VEC[i][15:0]);
      check("R7 dest_idx", {13'b0, dest_idx}, {13'b0, VEC[i][59:57]});
    end
    // R12 under positive code
    instr = 16'h0200; #1; check("R12 p match", {15'b0, branch_match}, 16'h1);
    instr = 16'h0C00; #1; check("R12 p no match", {15'b0, branch_match}, 16'h0);
    // R8 zero: add -16 + 16
    set_cc(16'h1030, 16'h0010, 0, 16'h8000);
    check("R8 zero", {14'b0, cc}, 16'h0001);
    instr = 16'h0400; #1; check("R12 z match", {15'b0, branch_match}, 16'h1);
    instr = 16'h0A00; #1; check("R12 z no match", {15'b0, branch_match}, 16'h0);
    // R8 negative: NOT 0x7FFF = 0x8000
    set_cc(16'h9000, 16'h7FFF, 0, 16'h0000);
    check("R8 negative", {14'b0, cc}, 16'h0002);
    instr = 16'h0800; #1; check("R12 n match", {15'b0, branch_match}, 16'h1);
    instr = 16'h0600; #1; check("R12 n no match", {15'b0, branch_match}, 16'h0);
    // R10 hold: result would be zero but no strobe
    @(negedge clk);
    instr = 16'h5020; src_a = 16'h1234; cc_sel_load = 0;
    @(negedge clk); @(negedge clk);
    check("R10 hold", {14'b0, cc}, 16'h0002);
    // R9 load path positive while result would be zero
    set_cc(16'h5020, 16'h1234, 1, 16'h7FFF);
    check("R9 load positive", {14'b0, cc}, 16'h0000);
    set_cc(16'h1001, 16'h0001, 1, 16'h0000);
    check("R9 load zero", {14'b0, cc}, 16'h0001);
    set_cc(16'h5020, 16'h0000, 1, 16'hFFFF);
    check("R9 load negative", {14'b0, cc}, 16'h0002);
    // R8 positive from result
    set_cc(16'h1021, 16'h0001, 0, 16'hFFFF);
    check("R8 positive", {14'b0, cc}, 16'h0000);
    // R11 asynchronous clear
    set_cc(16'h9000, 16'h0000, 0, 16'h0000);
    #1 rst_n = 0; #1;
    check("R11 async clear", {14'b0, cc}, 16'h0000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule